// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Stall Control

This unit serves a five-stage pipeline whose branches are resolved in decode. It takes the two source register indices read in decode and compares them with the destinations of the instructions further down the pipe. For each operand it picks the freshest copy available: the register file, the ALU result held in the memory stage, or the value being written back. A branch comparison in decode therefore sees current operands.

When a needed value does not exist yet, the unit raises `stall`. Two cases cause this: a load that has not reached memory, or an ALU result still in execute that a branch needs now. The surrounding pipeline responds by holding the PC and the fetch/decode register and by zeroing the execute-stage control lines for one cycle. When decode resolves a taken branch or a jump and the pipe is not stalled, the unit raises `flush` to clear the wrongly fetched instruction in the fetch/decode register.

The unit is purely combinational and sits between the pipeline registers. No stream carries data through it, so every pin is a plain level signal and no back-pressure handshake applies.

Top module: `decode_hazard_unit`

## Requirements
- R1: A source index of 0 never matches a producer. The unit selects the register file for it and never stalls because of it.
- R2: A producer whose write-enable is low is ignored for forwarding and for stalling.
- R3: If a used, nonzero source matches a memory-stage producer that writes and is not a load, its select is 2'b01 (memory-stage ALU result).
- R4: If a used, nonzero source has no memory-stage match but matches a writing write-back producer, its select is 2'b10 (write-back value). The select code 2'b00 means the register file, and 2'b11 is never produced.
- R5: When both the memory stage and write-back match a source, the memory stage wins. If the memory-stage producer is a load, the select is 2'b00 and write-back is never used.
- R6: A load in execute whose destination matches a used, nonzero source raises `stall`, whether or not decode holds a branch.
- R7: A writing non-load in execute that matches a used source of a branch in decode raises `stall`. The same match without a branch raises no stall.
- R8: A load in the memory stage that matches a used source of a branch in decode raises `stall`. The same match without a branch raises no stall.
- R9: `flush` is high exactly when `id_redirect` is high and `stall` is low.
- R10: A source whose use flag is low causes no stall and selects 2'b00, whatever the producers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | RW | First source register index in decode |
| id_rt | input | RW | Second source register index in decode |
| id_rs_used | input | 1 | Decode instruction reads the first source |
| id_rt_used | input | 1 | Decode instruction reads the second source |
| id_branch | input | 1 | Decode instruction compares operands for a branch |
| id_redirect | input | 1 | Decode resolved a taken branch or a jump |
| ex_dst | input | RW | Destination index of the instruction in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | RW | Destination index of the instruction in memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | RW | Destination index of the instruction in write-back |
| wb_wr | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand source select for the first source |
| fwd_b | output | 2 | Operand source select for the second source |
| stall | output | 1 | Hold PC and fetch/decode register, bubble execute |
| flush | output | 1 | Clear the fetch/decode register |

## Verification
The unit holds no state, so a wrong match or priority term shows at the ports in the same cycle as the offending inputs. It appears either as a wrong select code or as a missing or spurious stall. A dropped stall lets a branch compare stale data, and a spurious one costs a lost cycle. A flush during a stall would discard the very branch that is waiting to resolve. Each of these is visible on the very vector that triggers it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_operand_track.sv
module hzd_operand_track
  import hzd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          used,
  input  logic          is_branch,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output fwd_sel_e      sel,
  output logic          hold
);
  logic live, ex_hit, mem_hit, wb_hit;

  always_comb begin
    live    = used && (src != '0);
    ex_hit  = live && ex_wr  && (ex_dst  == src);
    mem_hit = live && mem_wr && (mem_dst == src);
    wb_hit  = live && wb_wr  && (wb_dst  == src);

    // value not yet producible for the reader in decode
    hold = (ex_hit && (ex_load || is_branch)) ||
           (mem_hit && mem_load && is_branch);

    // newest producer first; a load in memory masks older write-back data
    if (mem_hit)     sel = mem_load ? FWD_RF : FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_redirect_gate.sv
module hzd_redirect_gate (
  input  logic redirect,
  input  logic hold,
  output logic flush
);
  // a stalled branch has not truly resolved; flush waits for it
  assign flush = redirect && !hold;
endmodule

// File: rtl/decode_hazard_unit.sv
module decode_hazard_unit
  import hzd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_used,
  input  logic          id_branch,
  input  logic          id_redirect,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          flush
);
  localparam int NSRC = 2;

  logic [RW-1:0] src_idx  [NSRC];
  logic          src_used [NSRC];
  fwd_sel_e      src_sel  [NSRC];
  logic [NSRC-1:0] src_hold;

  assign src_idx[0]  = id_rs;
  assign src_idx[1]  = id_rt;
  assign src_used[0] = id_rs_used;
  assign src_used[1] = id_rt_used;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_operand_track #(.RW(RW)) u_track (
      .src      (src_idx[g]),
      .used     (src_used[g]),
      .is_branch(id_branch),
      .ex_dst   (ex_dst),
      .ex_wr    (ex_wr),
      .ex_load  (ex_load),
      .mem_dst  (mem_dst),
      .mem_wr   (mem_wr),
      .mem_load (mem_load),
      .wb_dst   (wb_dst),
      .wb_wr    (wb_wr),
      .sel      (src_sel[g]),
      .hold     (src_hold[g])
    );
  end

  assign stall = |src_hold;
  assign fwd_a = src_sel[0];
  assign fwd_b = src_sel[1];

  hzd_redirect_gate u_gate (
    .redirect(id_redirect),
    .hold    (stall),
    .flush   (flush)
  );
endmodule

// File: rtl/decode_hazard_unit_chk.sv
module decode_hazard_unit_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] id_rs,
  input logic [RW-1:0] id_rt,
  input logic          id_rs_used,
  input logic          id_rt_used,
  input logic          id_branch,
  input logic          id_redirect,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_load,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_load,
  input logic [RW-1:0] wb_dst,
  input logic          wb_wr,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall,
  input logic          flush
);
  always_comb begin
    // R9
    flush_not_stalled_chk: assert (!(flush && stall));
    // R9
    flush_has_cause_chk: assert (!flush || id_redirect);
    // R1
    zero_src_chk: assert ((id_rs != '0 || fwd_a == 2'b00) && (id_rt != '0 || fwd_b == 2'b00));
    // R2
    quiet_producers_chk: assert (ex_wr || mem_wr || wb_wr || (!stall && fwd_a == 2'b00 && fwd_b == 2'b00));
    // R4
    legal_sel_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    // R6
    load_use_chk: assert (!(ex_wr && ex_load &&
                           ((id_rs_used && id_rs != '0 && ex_dst == id_rs) ||
                            (id_rt_used && id_rt != '0 && ex_dst == id_rt))) || stall);
    // R7
    branch_ex_chk: assert (!(id_branch && ex_wr && id_rs_used && id_rs != '0 && ex_dst == id_rs) || stall);
    // R3
    mem_fwd_chk: assert (!(id_rs_used && id_rs != '0 && mem_wr && !mem_load && mem_dst == id_rs) || fwd_a == 2'b01);
    // R4
    wb_fwd_chk: assert (!(id_rs_used && id_rs != '0 && wb_wr && wb_dst == id_rs &&
                          !(mem_wr && mem_dst == id_rs)) || fwd_a == 2'b10);
  end
endmodule

bind decode_hazard_unit decode_hazard_unit_chk #(.RW(RW)) u_chk (.*);

// File: tb/decode_hazard_unit_test.sv
module decode_hazard_unit_test;
  localparam int RW = 5;
  localparam int NV = 19;

  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt;
    logic rsu; logic rtu; logic br; logic rd;
    logic [4:0] exd; logic exw; logic exm;
    logic [4:0] md;  logic mw;  logic mm;
    logic [4:0] wd;  logic ww;
    logic [1:0] efa; logic [1:0] efb; logic est; logic efl;
    logic [7:0] req;
  } vec_t;

  localparam logic T = 1'b1;
  localparam logic F = 1'b0;

  localparam vec_t VEC [NV] = '{
    // R2 idle
    '{5'd0,5'd0,F,F,F,F, 5'd0,F,F, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,F,F, 8'd2},
    // R3 first operand from memory stage
    '{5'd3,5'd4,T,T,F,F, 5'd0,F,F, 5'd3,T,F, 5'd0,F, 2'b01,2'b00,F,F, 8'd3},
    // R3 second operand
    '{5'd3,5'd4,T,T,F,F, 5'd0,F,F, 5'd4,T,F, 5'd0,F, 2'b00,2'b01,F,F, 8'd3},
    // R4 write-back
    '{5'd3,5'd4,T,T,F,F, 5'd0,F,F, 5'd0,F,F, 5'd3,T, 2'b10,2'b00,F,F, 8'd4},
    // R5 memory beats write-back
    '{5'd3,5'd4,T,T,F,F, 5'd0,F,F, 5'd3,T,F, 5'd3,T, 2'b01,2'b00,F,F, 8'd5},
    // R1 register zero everywhere
    '{5'd0,5'd0,T,T,T,F, 5'd0,T,T, 5'd0,T,T, 5'd0,T, 2'b00,2'b00,F,F, 8'd1},
    // R2 matches with write-enable low
    '{5'd3,5'd3,T,T,T,F, 5'd3,F,T, 5'd3,F,T, 5'd3,F, 2'b00,2'b00,F,F, 8'd2},
    // R6 load-use, no branch
    '{5'd3,5'd4,T,T,F,F, 5'd4,T,T, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,T,F, 8'd6},
    // R6 load-use with branch
    '{5'd3,5'd4,T,T,T,F, 5'd3,T,T, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,T,F, 8'd6},
    // R7 branch needs execute ALU result
    '{5'd3,5'd4,T,T,T,F, 5'd3,T,F, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,T,F, 8'd7},
    // R7 same match without branch
    '{5'd3,5'd4,T,T,F,F, 5'd3,T,F, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,F,F, 8'd7},
    // R8 branch needs memory-stage load
    '{5'd3,5'd4,T,T,T,F, 5'd0,F,F, 5'd4,T,T, 5'd0,F, 2'b00,2'b00,T,F, 8'd8},
    // R8 without branch; R5 load masks write-back
    '{5'd3,5'd4,T,T,F,F, 5'd0,F,F, 5'd4,T,T, 5'd4,T, 2'b00,2'b00,F,F, 8'd8},
    // R9 redirect, no hazard
    '{5'd3,5'd4,T,T,T,T, 5'd0,F,F, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,F,T, 8'd9},
    // R9 redirect while stalled
    '{5'd3,5'd4,T,T,T,T, 5'd3,T,F, 5'd0,F,F, 5'd0,F, 2'b00,2'b00,T,F, 8'd9},
    // R10 first source unused
    '{5'd3,5'd4,F,T,F,F, 5'd3,T,T, 5'd3,T,F, 5'd0,F, 2'b00,2'b00,F,F, 8'd10},
    // R10 second source unused
    '{5'd3,5'd4,T,F,T,F, 5'd4,T,T, 5'd0,F,F, 5'd4,T, 2'b00,2'b00,F,F, 8'd10},
    // R4 mixed sources
    '{5'd5,5'd6,T,T,F,F, 5'd0,F,F, 5'd5,T,F, 5'd6,T, 2'b01,2'b10,F,F, 8'd4},
    // R5 both operands same register, branch, no stall
    '{5'd7,5'd7,T,T,T,F, 5'd0,F,F, 5'd7,T,F, 5'd7,T, 2'b01,2'b01,F,F, 8'd5}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] id_rs, id_rt, ex_dst, mem_dst, wb_dst;
  logic id_rs_used, id_rt_used, id_branch, id_redirect;
  logic ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0] fwd_a, fwd_b;
  logic stall, flush;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  decode_hazard_unit #(.RW(RW)) uut (.*);

  task automatic apply(input vec_t v);
    id_rs = v.rs; id_rt = v.rt; id_rs_used = v.rsu; id_rt_used = v.rtu;
    id_branch = v.br; id_redirect = v.rd;
    ex_dst = v.exd; ex_wr = v.exw; ex_load = v.exm;
    mem_dst = v.md; mem_wr = v.mw; mem_load = v.mm;
    wb_dst = v.wd; wb_wr = v.ww;
  endtask

  task automatic check(input vec_t v, input string tag);
    n_chk++;
    if (fwd_a !== v.efa || fwd_b !== v.efb || stall !== v.est || flush !== v.efl) begin
      n_fail++;
      $display("FAIL R%0d %s: fwd_a=%b fwd_b=%b stall=%b flush=%b expected %b %b %b %b",
               v.req, tag, fwd_a, fwd_b, stall, flush, v.efa, v.efb, v.est, v.efl);
    end
  endtask

  initial begin
    vec_t v;
    apply(VEC[0]);
    @(negedge clk);
    // R2 idle state right after start
    check(VEC[0], "idle state");
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      apply(VEC[i]);
      @(negedge clk);
      check(VEC[i], $sformatf("vector %0d", i));
    end
    // R3 sweep every nonzero index through the memory stage
    for (int r = 1; r < 32; r++) begin
      @(posedge clk);
      v = VEC[0];
      v.rs = 5'(r); v.rt = 5'(r); v.rsu = T; v.rtu = T;
      v.md = 5'(r); v.mw = T; v.wd = 5'(r); v.ww = T;
      v.efa = 2'b01; v.efb = 2'b01; v.req = 8'd3;
      apply(v);
      @(negedge clk);
      check(v, $sformatf("R3 sweep index %0d", r));
    end
    // R1 zero source against a load in execute with a branch
    @(posedge clk);
    v = VEC[0];
    v.rsu = T; v.rtu = T; v.br = T; v.rd = T; v.exw = T; v.exm = T;
    v.efl = T; v.req = 8'd1;
    apply(v);
    @(negedge clk);
    check(v, "R1 zero source with load in execute");
    // R9 flush withheld by memory-stage load feeding branch (R8 stall)
    @(posedge clk);
    v = VEC[11]; v.rd = T; v.req = 8'd9;
    apply(v);
    @(negedge clk);
    check(v, "R9 redirect blocked by load in memory");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule